// File: doc/BRIEF.md
# DC-Removal Filter with Freeze

This block takes a stream of signed 24-bit samples from a decimation stage and removes their DC component. It keeps a running estimate of the DC level and subtracts that estimate from each sample. The estimate is a leaky integrator that tracks the input slowly, at a rate set by a shift parameter. A freeze input stops the estimate from changing. While frozen, the held value is still subtracted from every sample, so a fixed offset is removed and a DC measurement stays steady.

Each accepted sample produces one corrected sample, registered, one clock later. The current estimate is also driven out so that it can be observed. Reset is asynchronous and active-low. Its release is synchronised to the clock inside the block.

Top module: `dc_trim`

## Requirements
- R1: `out_valid` is `in_valid` delayed by exactly one clock. Each accepted sample yields exactly one output sample.
- R2: For an accepted sample x, `out_data` in the next cycle is x minus E, saturated. E is the value `dc_est` showed in the cycle the sample was accepted, before that sample updates the estimate.
- R3: When freeze is 0, each accepted sample updates the accumulator A as A += ((x·2^K) − A) >>> K. The shift is arithmetic, and A is a signed (24+K)-bit value with K fractional bits.
- R4: When freeze is 1, accepted samples leave the accumulator, and therefore `dc_est`, unchanged.
- R5: While frozen, the held estimate is still subtracted from every accepted sample.
- R6: After freeze returns to 0, tracking continues from the held accumulator value, without clearing it.
- R7: `out_data` saturates to the range −2^23 … 2^23−1. Results below the range give −2^23 (0x800000), and results above it give 2^23−1 (0x7FFFFF).
- R8: After reset, `dc_est` is 0, `out_valid` is 0 and `out_data` is 0.
- R9: In cycles with `in_valid` low, `dc_est` and `out_data` keep their values.
- R10: `dc_est` equals floor(A / 2^K), the integer part of the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| in_valid | input | 1 | Sample strobe from the decimator |
| in_data | input | 24 | Signed input sample |
| freeze | input | 1 | 1 holds the DC estimate; 0 lets it track |
| out_valid | output | 1 | Corrected-sample strobe |
| out_data | output | 24 | Signed corrected sample, saturated |
| dc_est | output | 24 | Current DC estimate (integer part of the accumulator) |

## Verification
A wrong accumulator value shows on `dc_est` at the clock edge that accepts the sample. It shows on `out_data` one cycle later, as an offset in the corrected sample. A freeze leak shows as `dc_est` drifting across frozen samples. A wrong saturation boundary or sign only appears once the estimate has been driven to one rail and the input swings to the other, so the bench drives it there on purpose. A timing slip in the valid path shows as `out_valid` arriving one cycle early or late against the bench's one-cycle expectation.

// File: rtl/dc_trim_pkg.sv
package dc_trim_pkg;
  // Default sample width, leak shift and reset synchroniser depth.
  localparam int unsigned DEF_DW   = 24;
  localparam int unsigned DEF_K    = 10;
  localparam int unsigned DEF_SYNC = 2;
endpackage

// File: rtl/dc_trim_rst_sync.sv
module dc_trim_rst_sync #(
  parameter int unsigned STAGES = dc_trim_pkg::DEF_SYNC
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = 1'b1;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dc_trim_est.sv
module dc_trim_est #(
  parameter int unsigned DW = dc_trim_pkg::DEF_DW,
  parameter int unsigned K  = dc_trim_pkg::DEF_K
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp,
  input  logic                 hold,
  output logic signed [DW-1:0] est
);
  localparam int unsigned AW = DW + K;     // accumulator width
  localparam int unsigned XW = AW + 1;     // guard bit for the difference

  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_d;
  logic                 acc_en;
  logic signed [XW-1:0] x_ext;
  logic signed [XW-1:0] a_ext;
  logic signed [XW-1:0] err;
  logic signed [XW-1:0] step;
  logic signed [XW-1:0] sum;

  // Clock enable: only accepted samples while tracking.
  assign acc_en = smp_valid & ~hold;

  always_comb begin
    x_ext = {smp[DW-1], smp, {K{1'b0}}};
    a_ext = {acc_q[AW-1], acc_q};
    err   = x_ext - a_ext;
    step  = err >>> K;
    sum   = a_ext + step;
    acc_d = sum[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign est = acc_q[AW-1:K];
endmodule

// File: rtl/dc_trim_sub.sv
module dc_trim_sub #(
  parameter int unsigned DW = dc_trim_pkg::DEF_DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp,
  input  logic signed [DW-1:0] est,
  output logic                 res_valid,
  output logic signed [DW-1:0] res
);
  localparam logic signed [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  logic signed [DW:0]   wide;
  logic signed [DW-1:0] res_d;
  logic                 vld_q;
  logic signed [DW-1:0] res_q;

  always_comb begin
    wide = {smp[DW-1], smp} - {est[DW-1], est};
    if (wide[DW] != wide[DW-1]) res_d = wide[DW] ? MINV : MAXV;
    else                        res_d = wide[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= smp_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         res_q <= '0;
    else if (smp_valid) res_q <= res_d;
  end

  assign res_valid = vld_q;
  assign res       = res_q;
endmodule

// File: rtl/dc_trim.sv
module dc_trim #(
  parameter int unsigned DW    = dc_trim_pkg::DEF_DW,
  parameter int unsigned K     = dc_trim_pkg::DEF_K,
  parameter int unsigned SYNCN = dc_trim_pkg::DEF_SYNC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 freeze,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic signed [DW-1:0] dc_est
);
  logic                 rst_n_q;
  logic signed [DW-1:0] est_w;

  dc_trim_rst_sync #(.STAGES(SYNCN)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_q)
  );

  dc_trim_est #(.DW(DW), .K(K)) u_est (
    .clk(clk), .rst_n(rst_n_q), .smp_valid(in_valid), .smp(in_data),
    .hold(freeze), .est(est_w)
  );

  dc_trim_sub #(.DW(DW)) u_sub (
    .clk(clk), .rst_n(rst_n_q), .smp_valid(in_valid), .smp(in_data),
    .est(est_w), .res_valid(out_valid), .res(out_data)
  );

  assign dc_est = est_w;
endmodule

// File: rtl/dc_trim_chk.sv
module dc_trim_chk #(
  parameter int unsigned DW = dc_trim_pkg::DEF_DW
) (
  input logic                 clk,
  input logic                 rst_n_q,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_data,
  input logic                 freeze,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_data,
  input logic signed [DW-1:0] dc_est
);
  localparam logic signed [DW:0] MAXW = (DW+1)'(signed'({1'b0, {(DW-1){1'b1}}}));
  localparam logic signed [DW:0] MINW = -MAXW - 1;

  function automatic logic signed [DW-1:0] clip(input logic signed [DW:0] v);
    if (v > MAXW)      return MAXW[DW-1:0];
    else if (v < MINW) return MINW[DW-1:0];
    else               return v[DW-1:0];
  endfunction

  assert_valid_on_R1: assert property (@(posedge clk) disable iff (!rst_n_q)
    in_valid |=> out_valid);
  assert_valid_off_R1: assert property (@(posedge clk) disable iff (!rst_n_q)
    !in_valid |=> !out_valid);
  assert_result_R2: assert property (@(posedge clk) disable iff (!rst_n_q)
    in_valid |=> out_data == clip(($past(in_data) + (DW+1)'(0)) - $past(dc_est)));
  assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n_q)
    (in_valid && freeze) |=> $stable(dc_est));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n_q)
    !in_valid |=> ($stable(dc_est) && $stable(out_data)));
  assert_track_up_R3: assert property (@(posedge clk) disable iff (!rst_n_q)
    (in_valid && !freeze && (in_data > dc_est)) |=> (dc_est >= $past(dc_est)));
  assert_track_down_R3: assert property (@(posedge clk) disable iff (!rst_n_q)
    (in_valid && !freeze && (in_data < dc_est)) |=> (dc_est <= $past(dc_est)));
endmodule

bind dc_trim dc_trim_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n_q(rst_n_q), .in_valid(in_valid), .in_data(in_data),
  .freeze(freeze), .out_valid(out_valid), .out_data(out_data), .dc_est(dc_est)
);

// File: tb/dc_trim_tb.sv
`timescale 1ns/1ps
module dc_trim_tb;
  localparam int DW = 24;
  localparam int K  = 4;
  localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;
  localparam longint MINV = -(64'sd1 <<< (DW-1));

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [DW-1:0] in_data;
  logic freeze;
  logic out_valid;
  logic signed [DW-1:0] out_data;
  logic signed [DW-1:0] dc_est;

  int checks = 0;
  int errors = 0;
  longint acc_m = 0;   // model accumulator, K fractional bits

  always #2.5 clk = ~clk;

  dc_trim #(.DW(DW), .K(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .freeze(freeze), .out_valid(out_valid), .out_data(out_data), .dc_est(dc_est)
  );

  function automatic longint m_est();
    return acc_m >>> K;
  endfunction

  function automatic longint m_clip(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; drives one sample and checks at the following negedge.
  task automatic push(input longint x, input bit frz, input string req);
    longint exp_out;
    exp_out = m_clip(x - m_est());
    if (!frz) acc_m = acc_m + (((x <<< K) - acc_m) >>> K);
    in_valid = 1'b1;
    in_data  = DW'(x);
    freeze   = frz;
    @(negedge clk);
    chk({req, " R1 valid"}, longint'(out_valid), 1);
    chk({req, " R2 data"},  longint'(out_data), exp_out);
    chk({req, " R10 est"},  longint'(dc_est), m_est());
  endtask

  task automatic idle(input int n);
    longint hold_out;
    in_valid = 1'b0;
    @(negedge clk);
    hold_out = longint'(out_data);
    for (int i = 0; i < n; i++) begin
      in_data = DW'(i * 7777);
      @(negedge clk);
      chk("R1 idle valid", longint'(out_valid), 0);
      chk("R9 idle est",   longint'(dc_est), m_est());
      chk("R9 idle out",   longint'(out_data), hold_out);
    end
  endtask

  task automatic test_reset();
    chk("R8 valid", longint'(out_valid), 0);
    chk("R8 data",  longint'(out_data), 0);
    chk("R8 est",   longint'(dc_est), 0);
  endtask

  task automatic test_track();
    for (int i = 0; i < 6; i++) push(100000, 1'b0, "R3 track");
    idle(3);
    for (int i = 0; i < 4; i++) push(-250000 + i * 1000, 1'b0, "R3 neg");
    idle(1);
  endtask

  task automatic test_freeze();
    longint held;
    for (int i = 0; i < 3; i++) push(400000, 1'b0, "R3 pre");
    held = m_est();
    push(-3000000, 1'b1, "R5 frozen");
    push(5000000, 1'b1, "R5 frozen");
    push(12, 1'b1, "R5 frozen");
    chk("R4 held", longint'(dc_est), held);
    idle(2);
    push(400000, 1'b0, "R6 resume");
    push(400000, 1'b0, "R6 resume");
    idle(1);
  endtask

  task automatic test_saturate();
    for (int i = 0; i < 400; i++) push(MAXV, 1'b0, "R3 ramp hi");
    push(MINV, 1'b1, "R7 low rail");
    chk("R7 low rail", longint'(out_data), MINV);
    for (int i = 0; i < 500; i++) push(MINV, 1'b0, "R3 ramp lo");
    push(MAXV, 1'b1, "R7 high rail");
    chk("R7 high rail", longint'(out_data), MAXV);
    idle(1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    freeze   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_track();
    test_freeze();
    test_saturate();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule